// File: doc/BRIEF.md
# Program Lock and Encrypted Verify Guard

This block sits between the programming port of a small microcontroller and its on-chip program store. It keeps three lock bits and a 64-entry table of encryption bytes, and it commits a code byte, an encryption byte or a lock bit only after enough programming pulses have arrived with address, data and mode held steady. Bytes read back in verify mode are never raw. Each is the stored code byte XNORed with the encryption byte that the low six address bits select. A signature read returns fixed identification bytes.

The lock bits form a cumulative ladder. The first bit stops further code and key programming. It also stops table-lookup instructions running from external memory from reading internal code, and it freezes the external-access level at the value captured during reset. The second bit adds a verify block. The third bit also forbids execution from external memory. The nonvolatile cells are modelled as registers that reset does not touch. A one-cycle erase input returns code, encryption bytes and lock bits to the unprogrammed state.

Top module: `plock_guard`

## Requirements
- R1: After erase, with no write since, every verify read returns 0xFF. After reset, the read output is 0xFF and all four permission flags are 1.
- R2: A verify read (mode 3'd2) presented at one clock edge yields code[addr] XNOR key[addr[5:0]] on rd_data_o after the second rising edge.
- R3: While the selected encryption byte is 0xFF, a verify read returns the stored code byte unchanged.
- R4: A code address that was never programmed reads back in verify mode as the selected encryption byte itself.
- R5: In code-program mode (3'd1), a byte is stored on the 5th counted pulse and not before.
- R6: In key-program mode (3'd3, entry addr[5:0]) and lock modes (3'd4, 3'd5, 3'd6 for bits 1, 2, 3), the write takes effect on the 25th counted pulse and not before.
- R7: Any change of mode, address or data restarts the pulse count. A pulse in the same cycle as the change is not counted.
- R8: With lock bit 1 set, allow_prog_o and allow_tbl_o are 0, code and key writes leave storage unchanged, and ea_eff_o holds the ea_i level seen during the last reset.
- R9: With lock bits 1 and 2 set, allow_verify_o is 0 and every verify read returns 0xFF.
- R10: With all three lock bits set, allow_ext_o is 0. Below that level it is 1.
- R11: Signature reads (mode 3'd7) return 0x89 at address 0x030, 0x58 at 0x031, DEV_CODE (0x51 by default) at 0x060, and 0xFF elsewhere, at any lock level.
- R12: Erase clears all lock bits, sets all encryption bytes to 0xFF and marks every code byte unprogrammed. Reset leaves all three untouched.
- R13: In idle (3'd0) and in all programming modes, rd_data_o is 0xFF two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; samples ea_i |
| erase_i | input | 1 | One-cycle erase of all nonvolatile state |
| mode_i | input | 3 | Operation select (encodings in R2, R5, R6, R11, R13) |
| addr_i | input | 15 | Byte address |
| data_i | input | 8 | Byte to program |
| pulse_i | input | 1 | Programming pulse, one cycle high per pulse |
| ea_i | input | 1 | External-access pin level |
| rd_data_o | output | 8 | Verify or signature byte, two-cycle latency |
| allow_verify_o | output | 1 | Verify reads permitted |
| allow_prog_o | output | 1 | Code and key programming permitted |
| allow_tbl_o | output | 1 | Table lookups from external code may read internal memory |
| allow_ext_o | output | 1 | Execution from external memory permitted |
| ea_eff_o | output | 1 | Effective external-access level |

## Verification
A corrupted encryption byte appears on the verify read of every address that shares its low six bits, two edges after the read is presented. A wrong lock bit changes a permission flag in the same cycle it is set. A miscounting pulse counter shows up as a byte that is present or missing on the next verify of that address. The bench therefore does each programming step with one pulse short of the count and then with the full count, and probes an address from a second 64-byte page so that a key-index fault shows up.

// File: rtl/plock_pkg.sv
package plock_pkg;
  typedef enum logic [2:0] {
    M_IDLE      = 3'd0,
    M_PROG_CODE = 3'd1,
    M_VERIFY    = 3'd2,
    M_PROG_KEY  = 3'd3,
    M_LOCK1     = 3'd4,
    M_LOCK2     = 3'd5,
    M_LOCK3     = 3'd6,
    M_SIG       = 3'd7
  } plk_mode_e;

  localparam int SIG_A0 = 'h030;
  localparam int SIG_A1 = 'h031;
  localparam int SIG_A2 = 'h060;
  localparam logic [7:0] SIG_B0 = 8'h89;
  localparam logic [7:0] SIG_B1 = 8'h58;

  function automatic logic is_prog_mode(plk_mode_e m);
    return (m == M_PROG_CODE) || (m == M_PROG_KEY) ||
           (m == M_LOCK1) || (m == M_LOCK2) || (m == M_LOCK3);
  endfunction
endpackage

// File: rtl/plock_pulse_ctr.sv
module plock_pulse_ctr
  import plock_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DW      = 8,
  parameter int SHORT_N = 5,
  parameter int LONG_N  = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  plk_mode_e         mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic              pulse_i,
  output logic              commit_o
);
  localparam int CW = $clog2(LONG_N + 1);

  plk_mode_e         mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     data_q;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     need;
  logic              changed, counting, last;

  assign changed  = (mode_i != mode_q) || (addr_i != addr_q) || (data_i != data_q);
  assign counting = pulse_i && is_prog_mode(mode_i);
  assign need     = (mode_i == M_PROG_CODE) ? CW'(SHORT_N) : CW'(LONG_N);
  assign last     = (cnt_q == need - CW'(1));
  assign commit_o = counting && !changed && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_IDLE;
      addr_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_i;
      addr_q <= addr_i;
      data_q <= data_i;
      if (changed)       cnt_q <= '0;
      else if (counting) cnt_q <= last ? '0 : cnt_q + CW'(1);
    end
  end

  // R7: a commit is only possible with inputs steady since the previous cycle
  a_r7_commit_steady: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> ($stable(mode_i) && $stable(addr_i) && $stable(data_i)));
endmodule

// File: rtl/plock_code_mem.sv
module plock_code_mem #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          erase_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld_q = '0;
  logic [DW-1:0]    rdata_q;
  logic             rvld_q;

  // plain array with one write and one registered read port
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_q <= mem[raddr_i];
  end

  // programmed flags kept apart so erase is a single cycle
  always_ff @(posedge clk) begin
    if (erase_i)   vld_q <= '0;
    else if (we_i) vld_q[waddr_i] <= 1'b1;
    rvld_q <= vld_q[raddr_i];
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvld_q;
endmodule

// File: rtl/plock_key_lock.sv
module plock_key_lock #(
  parameter int KEYS = 64,
  parameter int DW   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    erase_i,
  input  logic                    key_we_i,
  input  logic [$clog2(KEYS)-1:0] key_widx_i,
  input  logic [DW-1:0]           key_wdata_i,
  input  logic [2:0]              lock_set_i,
  input  logic [$clog2(KEYS)-1:0] key_ridx_i,
  input  logic                    ea_i,
  output logic [DW-1:0]           key_rdata_o,
  output logic                    ea_eff_o,
  output logic                    allow_verify_o,
  output logic                    allow_prog_o,
  output logic                    allow_tbl_o,
  output logic                    allow_ext_o
);
  localparam int KW = $clog2(KEYS);

  logic [KEYS-1:0][DW-1:0] key_q  = '1;
  logic [2:0]              lock_q = '0;
  logic [DW-1:0]           key_rd_q;
  logic                    ea_lat_q, ea_eff_q;

  always_ff @(posedge clk) begin
    for (int i = 0; i < KEYS; i++) begin
      if (erase_i)
        key_q[i] <= '1;
      else if (key_we_i && (key_widx_i == KW'(i)))
        key_q[i] <= key_wdata_i;
    end
    key_rd_q <= key_q[key_ridx_i];
  end

  always_ff @(posedge clk) begin
    if (erase_i) lock_q <= '0;
    else         lock_q <= lock_q | lock_set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_lat_q <= ea_i;
      ea_eff_q <= ea_i;
    end else begin
      ea_eff_q <= lock_q[0] ? ea_lat_q : ea_i;
    end
  end

  assign key_rdata_o    = key_rd_q;
  assign ea_eff_o       = ea_eff_q;
  assign allow_prog_o   = ~lock_q[0];
  assign allow_tbl_o    = ~lock_q[0];
  assign allow_verify_o = ~(lock_q[0] & lock_q[1]);
  assign allow_ext_o    = ~(&lock_q);

  // R8: once locked, the encryption table holds until an erase
  a_r8_key_frozen: assert property (@(posedge clk) disable iff (rst)
    (!allow_prog_o && !erase_i) |=> $stable(key_q));
endmodule

// File: rtl/plock_guard.sv
module plock_guard
  import plock_pkg::*;
#(
  parameter int         ADDR_W   = 15,
  parameter int         DW       = 8,
  parameter int         CODE_AW  = 10,
  parameter int         KEYS     = 64,
  parameter int         SHORT_N  = 5,
  parameter int         LONG_N   = 25,
  parameter logic [7:0] DEV_CODE = 8'h51
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase_i,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic              pulse_i,
  input  logic              ea_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              allow_verify_o,
  output logic              allow_prog_o,
  output logic              allow_tbl_o,
  output logic              allow_ext_o,
  output logic              ea_eff_o
);
  localparam int KW = $clog2(KEYS);

  plk_mode_e     mode_e;
  logic          commit;
  logic          code_we, key_we;
  logic [2:0]    lock_set;
  logic [DW-1:0] code_rd, key_rd, sig_byte;
  logic          code_vld;

  plk_mode_e     s1_mode;
  logic          s1_vok;
  logic [DW-1:0] s1_sig;
  logic [DW-1:0] rd_q;

  assign mode_e = plk_mode_e'(mode_i);

  plock_pulse_ctr #(
    .ADDR_W(ADDR_W), .DW(DW), .SHORT_N(SHORT_N), .LONG_N(LONG_N)
  ) u_ctr (
    .clk(clk), .rst(rst), .mode_i(mode_e), .addr_i(addr_i),
    .data_i(data_i), .pulse_i(pulse_i), .commit_o(commit)
  );

  assign code_we  = commit && (mode_e == M_PROG_CODE) && allow_prog_o && !erase_i;
  assign key_we   = commit && (mode_e == M_PROG_KEY)  && allow_prog_o && !erase_i;
  assign lock_set = {commit && (mode_e == M_LOCK3),
                     commit && (mode_e == M_LOCK2),
                     commit && (mode_e == M_LOCK1)};

  plock_code_mem #(.AW(CODE_AW), .DW(DW)) u_code (
    .clk(clk), .erase_i(erase_i), .we_i(code_we),
    .waddr_i(addr_i[CODE_AW-1:0]), .wdata_i(data_i),
    .raddr_i(addr_i[CODE_AW-1:0]), .rdata_o(code_rd), .rvalid_o(code_vld)
  );

  plock_key_lock #(.KEYS(KEYS), .DW(DW)) u_key (
    .clk(clk), .rst(rst), .erase_i(erase_i),
    .key_we_i(key_we), .key_widx_i(addr_i[KW-1:0]), .key_wdata_i(data_i),
    .lock_set_i(lock_set), .key_ridx_i(addr_i[KW-1:0]), .ea_i(ea_i),
    .key_rdata_o(key_rd), .ea_eff_o(ea_eff_o),
    .allow_verify_o(allow_verify_o), .allow_prog_o(allow_prog_o),
    .allow_tbl_o(allow_tbl_o), .allow_ext_o(allow_ext_o)
  );

  always_comb begin
    if      (addr_i == ADDR_W'(SIG_A0)) sig_byte = DW'(SIG_B0);
    else if (addr_i == ADDR_W'(SIG_A1)) sig_byte = DW'(SIG_B1);
    else if (addr_i == ADDR_W'(SIG_A2)) sig_byte = DW'(DEV_CODE);
    else                                sig_byte = '1;
  end

  // stage 1 lines up with the registered reads of both stores
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_mode <= M_IDLE;
      s1_vok  <= 1'b0;
      s1_sig  <= '1;
      rd_q    <= '1;
    end else begin
      s1_mode <= mode_e;
      s1_vok  <= allow_verify_o;
      s1_sig  <= sig_byte;
      case (s1_mode)
        M_VERIFY: rd_q <= s1_vok ? ((code_vld ? code_rd : '1) ~^ key_rd) : '1;
        M_SIG:    rd_q <= s1_sig;
        default:  rd_q <= '1;
      endcase
    end
  end

  assign rd_data_o = rd_q;

  // R9: a verify read issued while the verify lock holds returns all ones
  a_r9_verify_locked: assert property (@(posedge clk) disable iff (rst)
    (mode_e == M_VERIFY && !allow_verify_o) |=> ##1 (rd_data_o == '1));

  // R11: first signature byte
  a_r11_sig_first: assert property (@(posedge clk) disable iff (rst)
    (mode_e == M_SIG && addr_i == ADDR_W'(SIG_A0)) |=> ##1 (rd_data_o == DW'(SIG_B0)));

  // R13: idle and programming modes return all ones
  a_r13_quiet_ones: assert property (@(posedge clk) disable iff (rst)
    (mode_e != M_VERIFY && mode_e != M_SIG) |=> ##1 (rd_data_o == '1));
endmodule

// File: tb/plock_guard_test.sv
`timescale 1ns/1ps
module plock_guard_test;
  localparam logic [2:0] M_IDLE = 3'd0, M_CODE = 3'd1, M_VER = 3'd2, M_KEY = 3'd3,
                         M_L1 = 3'd4, M_L2 = 3'd5, M_L3 = 3'd6, M_SIG = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        erase_i = 1'b0;
  logic [2:0]  mode_i = M_IDLE;
  logic [14:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        pulse_i = 1'b0;
  logic        ea_i = 1'b1;
  logic [7:0]  rd_data_o;
  logic        allow_verify_o, allow_prog_o, allow_tbl_o, allow_ext_o, ea_eff_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  typedef struct { int due; logic [7:0] exp; string tag; } item_t;
  item_t sbq[$];
  item_t it;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  plock_guard uut (
    .clk(clk), .rst(rst), .erase_i(erase_i), .mode_i(mode_i), .addr_i(addr_i),
    .data_i(data_i), .pulse_i(pulse_i), .ea_i(ea_i), .rd_data_o(rd_data_o),
    .allow_verify_o(allow_verify_o), .allow_prog_o(allow_prog_o),
    .allow_tbl_o(allow_tbl_o), .allow_ext_o(allow_ext_o), .ea_eff_o(ea_eff_o)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops each expected byte in the cycle it is due
  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].due == cyc) begin
      it = sbq.pop_front();
      chk(it.tag, rd_data_o, it.exp);
    end
  end

  task automatic idle(int n);
    @(negedge clk);
    mode_i = M_IDLE; pulse_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [2:0] m, logic [14:0] a, logic [7:0] exp, string tag);
    item_t x;
    @(negedge clk);
    mode_i = m; addr_i = a; pulse_i = 1'b0;
    x.due = cyc + 2; x.exp = exp; x.tag = tag;
    sbq.push_back(x);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      pulse_i = 1'b1; @(negedge clk);
      pulse_i = 1'b0; @(negedge clk);
    end
  endtask

  task automatic prog(logic [2:0] m, logic [14:0] a, logic [7:0] d, int n);
    @(negedge clk);
    mode_i = m; addr_i = a; data_i = d; pulse_i = 1'b0;
    @(negedge clk);
    pulses(n);
    mode_i = M_IDLE;
    @(negedge clk);
  endtask

  task automatic do_erase();
    @(negedge clk); erase_i = 1'b1;
    @(negedge clk); erase_i = 1'b0;
  endtask

  task automatic flags(logic v, logic p, logic t, logic e, string tag);
    chk({tag, " verify"}, {7'd0, allow_verify_o}, {7'd0, v});
    chk({tag, " prog"},   {7'd0, allow_prog_o},   {7'd0, p});
    chk({tag, " tbl"},    {7'd0, allow_tbl_o},    {7'd0, t});
    chk({tag, " ext"},    {7'd0, allow_ext_o},    {7'd0, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset output", rd_data_o, 8'hFF);
    flags(1, 1, 1, 1, "R1 reset");
    do_erase();
    rd(M_VER, 15'h005, 8'hFF, "R1 erased verify");
    rd(M_VER, 15'h2AA, 8'hFF, "R1 erased verify hi");
    idle(3);

    // EA follows the pin while unlocked
    ea_i = 1'b0; idle(2);
    chk("R8 ea unlocked low", {7'd0, ea_eff_o}, 8'd0);
    ea_i = 1'b1; idle(2);
    chk("R8 ea unlocked high", {7'd0, ea_eff_o}, 8'd1);

    // R5: four pulses store nothing, five store the byte
    prog(M_CODE, 15'h005, 8'h3C, 4);
    rd(M_VER, 15'h005, 8'hFF, "R5 four pulses");
    prog(M_CODE, 15'h005, 8'h3C, 5);
    rd(M_VER, 15'h005, 8'h3C, "R5 R3 five pulses");
    idle(3);

    // R7: data change mid-count restarts the count
    @(negedge clk); mode_i = M_CODE; addr_i = 15'h006; data_i = 8'h11;
    @(negedge clk); pulses(3);
    data_i = 8'h12; @(negedge clk); pulses(2);
    rd(M_VER, 15'h006, 8'hFF, "R7 restart on data change");
    prog(M_CODE, 15'h006, 8'h12, 5);
    rd(M_VER, 15'h006, 8'h12, "R7 full count after change");
    idle(3);

    // R6: encryption byte needs 25 pulses
    prog(M_KEY, 15'h005, 8'hF0, 24);
    rd(M_VER, 15'h005, 8'h3C, "R6 key 24 pulses");
    prog(M_KEY, 15'h005, 8'hF0, 25);
    rd(M_VER, 15'h005, 8'h33, "R2 encrypted verify");
    rd(M_VER, 15'h045, 8'hF0, "R4 blank code shows key");
    rd(M_VER, 15'h006, 8'h12, "R3 ones key passes code");
    idle(3);

    // R11, R13
    rd(M_SIG, 15'h030, 8'h89, "R11 sig 030");
    rd(M_SIG, 15'h031, 8'h58, "R11 sig 031");
    rd(M_SIG, 15'h060, 8'h51, "R11 sig 060");
    rd(M_SIG, 15'h032, 8'hFF, "R11 sig other");
    rd(M_IDLE, 15'h005, 8'hFF, "R13 idle read");
    rd(M_CODE, 15'h005, 8'hFF, "R13 prog mode read");
    idle(3);

    // R6 and R8: lock bit 1
    prog(M_L1, 15'h000, 8'h00, 24);
    flags(1, 1, 1, 1, "R6 lock 24 pulses");
    prog(M_L1, 15'h000, 8'h00, 25);
    flags(1, 0, 0, 1, "R8 lock1");
    prog(M_CODE, 15'h007, 8'h55, 5);
    prog(M_KEY, 15'h007, 8'h00, 25);
    rd(M_VER, 15'h007, 8'hFF, "R8 writes blocked");
    rd(M_VER, 15'h005, 8'h33, "R8 verify still open");
    idle(3);
    ea_i = 1'b0; rst = 1'b1; idle(2);
    rst = 1'b0; ea_i = 1'b1; idle(3);
    chk("R8 ea latched", {7'd0, ea_eff_o}, 8'd0);
    flags(1, 0, 0, 1, "R12 lock survives reset");

    // R9: lock bit 2
    prog(M_L2, 15'h000, 8'h00, 25);
    flags(0, 0, 0, 1, "R9 R10 lock2");
    rd(M_VER, 15'h005, 8'hFF, "R9 verify blocked");
    rd(M_SIG, 15'h031, 8'h58, "R11 sig under lock");
    idle(3);

    // R10: lock bit 3
    prog(M_L3, 15'h000, 8'h00, 25);
    flags(0, 0, 0, 0, "R10 lock3");

    // R12: erase
    do_erase();
    idle(2);
    flags(1, 1, 1, 1, "R12 erase");
    chk("R12 ea follows pin", {7'd0, ea_eff_o}, 8'd1);
    rd(M_VER, 15'h005, 8'hFF, "R12 code cleared");
    rd(M_VER, 15'h045, 8'hFF, "R12 key cleared");
    idle(4);

    if (sbq.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", sbq.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule